// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Recognizer

This block watches a one-bit serial stream, sampled once per clock, and flags whenever the four most recent bits form either `1101` or `1110`. It is a Moore machine. Its state register holds the longest tail of the received bits that is still the start of one of the two patterns. The match flag is decoded from that state alone.

The two patterns share their first two bits, so both are tracked in a single merged graph of seven states. These are: nothing useful seen, `1`, `11`, `110`, `1101`, `111` and `1110`. The states are coded in three bits as the binary values 0 through 6. Matches may overlap. After a hit, the machine keeps whatever tail can still lead to the next hit, so a bit that completes one pattern can also start the next.

Top module: `dual_seq_detect`

## Requirements
- R1: When the last four sampled bits are `1101` (oldest first), `match_o` is 1 during the clock cycle that follows the edge sampling the final bit.
- R2: When the last four sampled bits are `1110` (oldest first), `match_o` is 1 during the clock cycle that follows the edge sampling the final bit.
- R3: In every other case `match_o` is 0. This includes streams such as `1111`, `1100`, `1011` and `0000`, and it includes fewer than four bits sampled since reset. A 0 sampled while `match_o` is 1 always drops it on the next cycle.
- R4: A clock edge with `rst_i` high (synchronous, active high) empties the machine. `match_o` is 0 in the following cycle, and no bit sampled before the reset contributes to a later match.
- R5: Matches of `1101` overlap. The stream `1101101` reports a hit after the fourth bit and again after the seventh bit.
- R6: A `1110` hit followed by a sampled 1 is at once a `1101` hit. The stream `11101` keeps `match_o` high for two consecutive cycles.
- R7: A run of three or more 1s followed by a 0 reports a `1110` hit, however long the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset to the empty state |
| bit_i | input | 1 | Serial data bit, sampled on each rising edge |
| match_o | output | 1 | High while the last four sampled bits form one of the two patterns |

## Verification
The block has no parameters, so the bench builds it in its single fixed form. That form reaches every state and transition of the seven-state graph. Directed streams cover back-to-back hits of the same pattern and the hand-off from one pattern straight into the other. They also cover long runs of 1s, reset in the middle of a prefix, and near-miss streams. A long random stream is then checked on every clock against a four-bit history window.

// File: rtl/dual_seq_pkg.sv
package dual_seq_pkg;

    // Prefix-tracking states; binary codes 0..6, code 7 unused.
    typedef enum logic [2:0] {
        ST_NONE  = 3'd0,  // no useful prefix
        ST_P1    = 3'd1,  // "1"
        ST_P11   = 3'd2,  // "11"
        ST_P110  = 3'd3,  // "110"
        ST_H1101 = 3'd4,  // "1101" hit
        ST_P111  = 3'd5,  // "111"
        ST_H1110 = 3'd6   // "1110" hit
    } seq_state_e;

    localparam int unsigned STATE_W = $bits(seq_state_e);

    function automatic logic state_is_hit(input seq_state_e s);
        return (s == ST_H1101) || (s == ST_H1110);
    endfunction

endpackage

// File: rtl/dual_seq_next.sv
module dual_seq_next
    import dual_seq_pkg::*;
(
    input  seq_state_e cur_i,
    input  logic       bit_i,
    output seq_state_e nxt_o
);

    always_comb begin
        nxt_o = ST_NONE;
        unique case (cur_i)
            ST_NONE:  nxt_o = bit_i ? ST_P1    : ST_NONE;
            ST_P1:    nxt_o = bit_i ? ST_P11   : ST_NONE;
            ST_P11:   nxt_o = bit_i ? ST_P111  : ST_P110;
            ST_P110:  nxt_o = bit_i ? ST_H1101 : ST_NONE;
            // after 1101: a 1 leaves tail "11", a 0 leaves nothing usable
            ST_H1101: nxt_o = bit_i ? ST_P11   : ST_NONE;
            // any run of ones keeps tail "111"
            ST_P111:  nxt_o = bit_i ? ST_P111  : ST_H1110;
            // after 1110: a 1 completes 1101 from the shared tail "110"
            ST_H1110: nxt_o = bit_i ? ST_H1101 : ST_NONE;
            default:  nxt_o = ST_NONE;  // unused code recovers to empty
        endcase
    end

endmodule

// File: rtl/dual_seq_detect.sv
module dual_seq_detect
    import dual_seq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic match_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    dual_seq_next u_next (
        .cur_i (state_q),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_NONE;
        else       state_q <= state_d;
    end

    assign match_o = state_is_hit(state_q);

    // R4: reset leaves the output low on the next cycle
    p_reset_quiet_r4: assert property (@(posedge clk_i)
        rst_i |=> !match_o);

    // R4: register never holds the unused code once out of reset
    p_legal_code_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != seq_state_e'(3'b111));

    // R1: prefix 110 plus a 1 raises the flag
    p_hit_1101_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_P110 && bit_i) |=> match_o);

    // R2 / R7: prefix of three or more ones plus a 0 raises the flag
    p_hit_1110_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_P111 && !bit_i) |=> match_o);

    // R3: a zero after a hit always drops the flag
    p_drop_on_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_o && !bit_i) |=> !match_o);

    // R6: 1110 followed by 1 stays high as a 1101 hit
    p_chain_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_H1110 && bit_i) |=> (match_o && state_q == ST_H1101));

    // R5: 1101 followed by 1 keeps the shared "11" tail
    p_overlap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_H1101 && bit_i) |=> (state_q == ST_P11));

endmodule

// File: tb/dual_seq_detect_tb.sv
module dual_seq_detect_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic match;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit hist[$];

    always #2 clk = ~clk;  // 250 MHz

    dual_seq_detect u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .bit_i   (din),
        .match_o (match)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: match_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: last four sampled bits equal 1101 or 1110.
    function automatic logic ref_hit();
        int n = hist.size();
        if (n < 4) return 1'b0;
        return hist[n-4] && hist[n-3] &&
               ((!hist[n-2] && hist[n-1]) || (hist[n-2] && !hist[n-1]));
    endfunction

    task automatic send(input logic b, input string req);
        din = b;
        @(posedge clk);
        #1;
        hist.push_back(b);
        if (hist.size() > 4) void'(hist.pop_front());
        chk(req, match, ref_hit());
    endtask

    task automatic send_str(input string s, input string req);
        for (int i = 0; i < s.len(); i++) send(s[i] == "1", req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = 1'b1;
        @(posedge clk);
        #1;
        chk("R4", match, 1'b0);
        rst = 1'b0;
        hist.delete();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R4", match, 1'b0);
        rst = 1'b0;

        // R1: single 1101 hit
        send_str("01101", "R1");
        chk("R1", match, 1'b1);
        send(1'b0, "R3");
        chk("R3", match, 1'b0);

        // R2: single 1110 hit
        do_reset();
        send_str("1110", "R2");
        chk("R2", match, 1'b1);

        // R3: near misses and short streams
        do_reset();
        send_str("111", "R3");
        chk("R3", match, 1'b0);
        do_reset();
        send_str("1111", "R3");
        chk("R3", match, 1'b0);
        do_reset();
        send_str("1100", "R3");
        chk("R3", match, 1'b0);
        do_reset();
        send_str("1011", "R3");
        chk("R3", match, 1'b0);
        do_reset();
        send_str("0000", "R3");
        chk("R3", match, 1'b0);

        // R4: reset discards a partial prefix
        do_reset();
        send_str("110", "R4");
        do_reset();
        send(1'b1, "R4");
        chk("R4", match, 1'b0);

        // R5: overlapping 1101 hits
        do_reset();
        send_str("1101", "R5");
        chk("R5", match, 1'b1);
        send_str("10", "R5");
        chk("R5", match, 1'b0);
        send(1'b1, "R5");
        chk("R5", match, 1'b1);

        // R6: 1110 then 1 stays high two cycles
        do_reset();
        send_str("1110", "R6");
        chk("R6", match, 1'b1);
        send(1'b1, "R6");
        chk("R6", match, 1'b1);

        // R7: long run of ones then zero
        do_reset();
        send_str("111111110", "R7");
        chk("R7", match, 1'b1);

        // R3: random stream against the history window, with occasional resets
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 400) == 0) do_reset();
            else send(1'($urandom % 2), "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule